// File: doc/BRIEF.md
# I/O Translation Unit Register Bank

This block is the software-visible register file of an I/O address translation unit. It is reached over a simple word-addressed register bus with separate read and write strobes, a word index, write data and read data. It holds the control word, the translation table base, two flush words, the fault status and fault address, one configuration word per bus slot, an arbitration enable word and a mask identification word. Each register keeps only its own writable bits and adds its own fixed bits. From the stored state it drives the translation enable, the table base and the lowest address of the translated window, so the translator can use them directly.

A separate capture port lets the translator record a failed access. The capture loads the fault status and fault address and raises a level interrupt. A two-state machine holds the interrupt. Its states are QUIET and RAISED. The transition QUIET to RAISED happens on a fault capture. The transition RAISED to QUIET happens on a clearing access: a write to the fault status, a write to the fault address, or a read of the fault status, provided no capture comes in the same cycle. A capture always returns the machine to RAISED, whatever state it was in.

Read data is combinational from the word index while the read strobe is high. The side effects of a read take effect at the clock edge on which the read strobe is sampled.

Top module: `iommu_regbank`

## Requirements
- R1: After reset the registers read as follows. Control (word 0x000) reads VERSION<<24. Arbitration (word 0x800) reads 0x00000008. Fault status (word 0x400) reads 0x00800000. Mask ID (word 0xC06) reads 0x23000000. Every other register reads 0, and irq is low.
- R2: The control word keeps only the written bits under 0x0000001D. It reads back as those bits ORed with VERSION in bits 31:24. Bit 0 drives xlate_en.
- R3: Control bits 4:2 hold a size code c. win_base equals 2^32 minus (2^24 << c), so code 0 gives 0xFF000000, code 2 gives 0xFC000000 and code 7 gives 0x80000000.
- R4: The table base word (word 0x001) keeps only the bits under 0x07FFFC00 and drives tbl_base.
- R5: The TLB flush word (word 0x005) and the page flush word (word 0x006) keep the whole written value.
- R6: A write to the fault status word stores the value ANDed with 0xFF0FFFFF, with bit 23 forced to 1, and clears irq.
- R7: A write to the fault address word (word 0x401) stores the whole value and clears irq. A read of the fault status word also clears irq. A read of any other word leaves irq unchanged.
- R8: The slot words (words 0x404 to 0x407, one per slot) each keep only the bits under 0x00010003. A write to one slot word leaves the others unchanged.
- R9: The arbitration word keeps the bits under 0x001F0000 and always reads bit 3 as 1.
- R10: A write to the mask ID word ORs the low 24 bits of the written value into the stored word and never clears a bit.
- R11: A word index that is not decoded reads as 0. A write to it changes no register.
- R12: When fault_we is high, the fault status becomes 0xC0820000, with bit 18 also set if fault_rd is high, and the fault address becomes fault_va. irq is high from the next cycle. If a bus write to either fault word comes in the same cycle, the capture wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| fault_we | input | 1 | Fault capture strobe from translator |
| fault_rd | input | 1 | Failed access was a read |
| fault_va | input | 32 | Failed page address |
| xlate_en | output | 1 | Translation enable |
| tbl_base | output | 32 | Masked table base |
| win_base | output | 32 | Lowest address of the translated window |
| irq | output | 1 | Level fault interrupt |

## Verification
The hardest case to reach is the collision between a fault capture and a bus write to a fault word in the same cycle. In that case the capture must win both the stored value and the interrupt state. The bench drives both strobes on the same falling edge, so that a single rising edge samples them together, and then reads back the fault status and irq. It also checks that a read of a word other than the fault status keeps irq high, and that a read of the fault status drops it.

// File: rtl/iommu_regs_pkg.sv
package iommu_regs_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_TBASE,
        SEL_TLBF,
        SEL_PGF,
        SEL_FSTAT,
        SEL_FADDR,
        SEL_SLOT,
        SEL_ARB,
        SEL_MASKID
    } reg_sel_e;

    localparam int WA_CTRL   = 'h000;
    localparam int WA_TBASE  = 'h001;
    localparam int WA_TLBF   = 'h005;
    localparam int WA_PGF    = 'h006;
    localparam int WA_FSTAT  = 'h400;
    localparam int WA_FADDR  = 'h401;
    localparam int WA_SLOT0  = 'h404;
    localparam int WA_ARB    = 'h800;
    localparam int WA_MASKID = 'hC06;

    localparam logic [31:0] CTRL_WMASK   = 32'h0000_001D;
    localparam logic [31:0] TBASE_WMASK  = 32'h07FF_FC00;
    localparam logic [31:0] FSTAT_WMASK  = 32'hFF0F_FFFF;
    localparam logic [31:0] FSTAT_FIXED  = 32'h0080_0000;
    localparam logic [31:0] SLOT_WMASK   = 32'h0001_0003;
    localparam logic [31:0] ARB_WMASK    = 32'h001F_0000;
    localparam logic [31:0] ARB_FIXED    = 32'h0000_0008;
    localparam logic [31:0] MASKID_WMASK = 32'h00FF_FFFF;
    localparam logic [31:0] MASKID_RST   = 32'h2300_0000;
    localparam logic [31:0] FAULT_CODE   = 32'hC082_0000;
    localparam logic [31:0] FAULT_RDBIT  = 32'h0004_0000;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_RAISED
    } irq_state_e;

endpackage

// File: rtl/iommu_addr_decode.sv
module iommu_addr_decode
    import iommu_regs_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_SLOTS = 4,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [SLOT_W-1:0] slot_idx
);

    logic [ADDR_W-1:0] slot_off;

    always_comb begin
        slot_off = addr - ADDR_W'(WA_SLOT0);
        slot_idx = slot_off[SLOT_W-1:0];
        if (addr == ADDR_W'(WA_CTRL))                 sel = SEL_CTRL;
        else if (addr == ADDR_W'(WA_TBASE))           sel = SEL_TBASE;
        else if (addr == ADDR_W'(WA_TLBF))            sel = SEL_TLBF;
        else if (addr == ADDR_W'(WA_PGF))             sel = SEL_PGF;
        else if (addr == ADDR_W'(WA_FSTAT))           sel = SEL_FSTAT;
        else if (addr == ADDR_W'(WA_FADDR))           sel = SEL_FADDR;
        else if (addr >= ADDR_W'(WA_SLOT0) &&
                 addr <  ADDR_W'(WA_SLOT0 + NUM_SLOTS)) sel = SEL_SLOT;
        else if (addr == ADDR_W'(WA_ARB))             sel = SEL_ARB;
        else if (addr == ADDR_W'(WA_MASKID))          sel = SEL_MASKID;
        else                                          sel = SEL_NONE;
    end

endmodule

// File: rtl/iommu_window_calc.sv
module iommu_window_calc #(
    parameter int WIN_MIN_LOG2 = 24,
    parameter int CODE_W       = 3
) (
    input  logic [CODE_W-1:0] code,
    output logic [31:0]       base
);

    logic [32:0] span;
    logic [32:0] diff;

    always_comb begin
        span = 33'd1 << (WIN_MIN_LOG2 + int'(code));
        diff = {1'b1, 32'd0} - span;
        base = diff[31:0];
    end

endmodule

// File: rtl/iommu_irq_fsm.sv
module iommu_irq_fsm
    import iommu_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic clear,
    output logic irq
);

    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (raise) state_d = IRQ_RAISED;
            IRQ_RAISED: if (!raise && clear) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/iommu_regbank.sv
module iommu_regbank
    import iommu_regs_pkg::*;
#(
    parameter int          ADDR_W       = 12,
    parameter int          NUM_SLOTS    = 4,
    parameter int          WIN_MIN_LOG2 = 24,
    parameter logic [7:0]  VERSION      = 8'h05
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              fault_we,
    input  logic              fault_rd,
    input  logic [31:0]       fault_va,
    output logic              xlate_en,
    output logic [31:0]       tbl_base,
    output logic [31:0]       win_base,
    output logic              irq
);

    localparam int          SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam logic [31:0] VER_WORD = {VERSION, 24'd0};

    reg_sel_e          sel;
    logic [SLOT_W-1:0] slot_idx;
    logic [31:0]       ctrl_q, tbase_q, tlbf_q, pgf_q;
    logic [31:0]       fstat_q, faddr_q, arb_q, maskid_q;
    logic [31:0]       slot_q [NUM_SLOTS];
    logic              irq_clear;

    iommu_addr_decode #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_dec (
        .addr     (bus_addr),
        .sel      (sel),
        .slot_idx (slot_idx)
    );

    iommu_window_calc #(.WIN_MIN_LOG2(WIN_MIN_LOG2), .CODE_W(3)) u_win (
        .code (ctrl_q[4:2]),
        .base (win_base)
    );

    always_comb begin
        irq_clear = (bus_wr && (sel == SEL_FSTAT || sel == SEL_FADDR)) ||
                    (bus_rd && sel == SEL_FSTAT);
    end

    iommu_irq_fsm u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (fault_we),
        .clear (irq_clear),
        .irq   (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            tbase_q  <= '0;
            tlbf_q   <= '0;
            pgf_q    <= '0;
            arb_q    <= ARB_FIXED;
            maskid_q <= MASKID_RST;
        end else if (bus_wr) begin
            unique case (sel)
                SEL_CTRL:   ctrl_q   <= bus_wdata & CTRL_WMASK;
                SEL_TBASE:  tbase_q  <= bus_wdata & TBASE_WMASK;
                SEL_TLBF:   tlbf_q   <= bus_wdata;
                SEL_PGF:    pgf_q    <= bus_wdata;
                SEL_ARB:    arb_q    <= (bus_wdata & ARB_WMASK) | ARB_FIXED;
                SEL_MASKID: maskid_q <= maskid_q | (bus_wdata & MASKID_WMASK);
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fstat_q <= FSTAT_FIXED;
            faddr_q <= '0;
        end else if (fault_we) begin
            fstat_q <= FAULT_CODE | (fault_rd ? FAULT_RDBIT : 32'd0);
            faddr_q <= fault_va;
        end else if (bus_wr && sel == SEL_FSTAT) begin
            fstat_q <= (bus_wdata & FSTAT_WMASK) | FSTAT_FIXED;
        end else if (bus_wr && sel == SEL_FADDR) begin
            faddr_q <= bus_wdata;
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (bus_wr && sel == SEL_SLOT && slot_idx == SLOT_W'(g))
                slot_q[g] <= bus_wdata & SLOT_WMASK;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_CTRL:   bus_rdata = ctrl_q | VER_WORD;
                SEL_TBASE:  bus_rdata = tbase_q;
                SEL_TLBF:   bus_rdata = tlbf_q;
                SEL_PGF:    bus_rdata = pgf_q;
                SEL_FSTAT:  bus_rdata = fstat_q;
                SEL_FADDR:  bus_rdata = faddr_q;
                SEL_SLOT:   bus_rdata = slot_q[slot_idx];
                SEL_ARB:    bus_rdata = arb_q;
                SEL_MASKID: bus_rdata = maskid_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    always_comb begin
        xlate_en = ctrl_q[0];
        tbl_base = tbase_q;
    end

endmodule

module iommu_regbank_chk
    import iommu_regs_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rd,
    input logic        bus_wr,
    input reg_sel_e    sel,
    input logic [31:0] bus_rdata,
    input logic        fault_we,
    input logic [31:0] fstat_q,
    input logic [31:0] maskid_q,
    input logic [31:0] win_base,
    input logic        irq
);

    a_r12_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        fault_we |=> irq);

    a_r12_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        fault_we |=> (fstat_q[31] && fstat_q[30]));

    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_FSTAT && !fault_we) |=> !irq);

    a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (sel == SEL_FSTAT || sel == SEL_FADDR) && !fault_we) |=> !irq);

    a_r6_fixed_bit: assert property (@(posedge clk) disable iff (!rst_n)
        fstat_q[23]);

    a_r10_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((maskid_q & $past(maskid_q)) == $past(maskid_q)));

    a_r3_window_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (win_base[31] && win_base[23:0] == 24'd0));

    a_r11_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (bus_rdata == 32'd0));

    a_r7_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_we && !(bus_rd && sel == SEL_FSTAT) &&
         !(bus_wr && (sel == SEL_FSTAT || sel == SEL_FADDR))) |=> $stable(irq));

endmodule

bind iommu_regbank iommu_regbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .sel       (sel),
    .bus_rdata (bus_rdata),
    .fault_we  (fault_we),
    .fstat_q   (fstat_q),
    .maskid_q  (maskid_q),
    .win_base  (win_base),
    .irq       (irq)
);

// File: tb/iommu_regbank_tb.sv
module iommu_regbank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          fault_we = 1'b0;
    logic          fault_rd = 1'b0;
    logic [31:0]   fault_va = '0;
    logic          xlate_en;
    logic [31:0]   tbl_base;
    logic [31:0]   win_base;
    logic          irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iommu_regbank #(.ADDR_W(AW), .VERSION(8'h05)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fault_we(fault_we), .fault_rd(fault_rd), .fault_va(fault_va),
        .xlate_en(xlate_en), .tbl_base(tbl_base), .win_base(win_base), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input int a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        #1;
        check(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        rd_check("R1 ctrl", 'h000, 32'h0500_0000);
        rd_check("R1 arb", 'h800, 32'h0000_0008);
        rd_check("R1 fstat", 'h400, 32'h0080_0000);
        rd_check("R1 maskid", 'hC06, 32'h2300_0000);
        rd_check("R1 tbase", 'h001, 32'h0);
        rd_check("R1 slot0", 'h404, 32'h0);
        check("R1 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_ctrl;
        wr_reg('h000, 32'hFFFF_FFFF);
        rd_check("R2 ctrl mask", 'h000, 32'h0500_001D);
        check("R2 xlate_en", {31'd0, xlate_en}, 32'd1);
        check("R3 code7", win_base, 32'h8000_0000);
        wr_reg('h000, 32'h0000_0008);
        check("R2 xlate_en off", {31'd0, xlate_en}, 32'd0);
        check("R3 code2", win_base, 32'hFC00_0000);
        wr_reg('h000, 32'h0000_0000);
        check("R3 code0", win_base, 32'hFF00_0000);
    endtask

    task automatic t_plain;
        wr_reg('h001, 32'hFFFF_FFFF);
        rd_check("R4 tbase", 'h001, 32'h07FF_FC00);
        check("R4 tbl_base port", tbl_base, 32'h07FF_FC00);
        wr_reg('h005, 32'hDEAD_BEEF);
        wr_reg('h006, 32'h1234_5678);
        rd_check("R5 tlb flush", 'h005, 32'hDEAD_BEEF);
        rd_check("R5 page flush", 'h006, 32'h1234_5678);
    endtask

    task automatic t_slots_arb;
        wr_reg('h406, 32'hFFFF_FFFF);
        rd_check("R8 slot2", 'h406, 32'h0001_0003);
        rd_check("R8 slot1 untouched", 'h405, 32'h0);
        rd_check("R8 slot3 untouched", 'h407, 32'h0);
        wr_reg('h800, 32'hFFFF_FFFF);
        rd_check("R9 arb mask", 'h800, 32'h001F_0008);
        wr_reg('h800, 32'h0);
        rd_check("R9 arb bit3", 'h800, 32'h0000_0008);
    endtask

    task automatic t_maskid;
        wr_reg('hC06, 32'h0000_00F0);
        rd_check("R10 or1", 'hC06, 32'h2300_00F0);
        wr_reg('hC06, 32'h0F00_000F);
        rd_check("R10 or2", 'hC06, 32'h2300_00FF);
        wr_reg('hC06, 32'h0);
        rd_check("R10 no clear", 'hC06, 32'h2300_00FF);
    endtask

    task automatic t_holes;
        wr_reg('h002, 32'hFFFF_FFFF);
        rd_check("R11 hole read", 'h002, 32'h0);
        rd_check("R11 ctrl intact", 'h000, 32'h0500_0000);
        rd_check("R11 tbase intact", 'h001, 32'h07FF_FC00);
        rd_check("R11 far hole", 'h7FF, 32'h0);
    endtask

    task automatic t_fault;
        wr_reg('h400, 32'hFFFF_FFFF);
        rd_check("R6 fstat mask", 'h400, 32'hFF8F_FFFF);
        wr_reg('h400, 32'h0);
        rd_check("R6 fstat fixed", 'h400, 32'h0080_0000);
        @(negedge clk);
        fault_we = 1'b1; fault_rd = 1'b1; fault_va = 32'h1234_5000;
        @(negedge clk);
        fault_we = 1'b0;
        check("R12 irq raised", {31'd0, irq}, 32'd1);
        rd_check("R7 other read keeps irq", 'h000, 32'h0500_0000);
        check("R7 irq held", {31'd0, irq}, 32'd1);
        rd_check("R12 fault addr", 'h401, 32'h1234_5000);
        check("R7 faddr read keeps irq", {31'd0, irq}, 32'd1);
        rd_check("R12 fstat read", 'h400, 32'hC086_0000);
        check("R7 fstat read clears", {31'd0, irq}, 32'd0);
        @(negedge clk);
        fault_we = 1'b1; fault_rd = 1'b0; fault_va = 32'hABCD_E000;
        @(negedge clk);
        fault_we = 1'b0;
        check("R12 irq again", {31'd0, irq}, 32'd1);
        wr_reg('h401, 32'h5555_AAAA);
        check("R7 faddr write clears", {31'd0, irq}, 32'd0);
        rd_check("R7 faddr stored", 'h401, 32'h5555_AAAA);
        rd_check("R12 fstat write fault", 'h400, 32'hC082_0000);
        @(negedge clk);
        fault_we = 1'b1; fault_va = 32'h0000_7000;
        wr_reg('h400, 32'h0);
        fault_we = 1'b0;
        wr_reg('h400, 32'h0000_0001);
        check("R6 fstat write clears", {31'd0, irq}, 32'd0);
        @(negedge clk);
        fault_we = 1'b1; fault_rd = 1'b1; fault_va = 32'h0000_9000;
        bus_addr = AW'('h400); bus_wdata = 32'h0; bus_wr = 1'b1;
        @(negedge clk);
        fault_we = 1'b0; bus_wr = 1'b0;
        check("R12 collision irq", {31'd0, irq}, 32'd1);
        rd_check("R12 collision fstat", 'h400, 32'hC086_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_plain();
        t_slots_arb();
        t_maskid();
        t_holes();
        t_fault();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule